// File: doc/BRIEF.md
# Exception Entry Vector Unit

This unit sends the program counter to a privileged handler whenever a trap, an interrupt or a software call is taken. The unit receives a cause code, an 8-bit call code, the current PC, a 64-bit handler base register and the current privileged-mode flag. On a one-cycle `take_i` pulse it registers three values: the handler PC, which is the base plus an offset chosen by the cause; the saved exception address; and a privileged-mode flag that is forced to 1. The saved exception address is the current PC with the current mode flag ORed into bit 0, so the return path can tell whether the trap came from privileged code.

Each hardware cause has a fixed handler offset, spaced 0x80 bytes apart. A software call cause instead selects one of two call regions, using bit 7 of the call code. The remaining seven bits choose a 64-byte slot inside that region. A cause code that is not defined does not redirect anything. It sets a sticky error flag and leaves the PC, the saved address and the mode flag as they were.

`take_i` is a plain control strobe that is sampled on every rising clock edge. The unit accepts a take in every cycle and never applies back-pressure, so it has no ready signal. The upstream logic that chooses the cause must hold the data inputs valid in the cycle where `take_i` is high.

Top module: `exc_vector_unit`

## Requirements
- R1: On a take whose cause is a fixed cause, the handler offset is cause×0x80. The cause encodings are: reset 0 (0x000), machine check 1 (0x080), interprocessor interrupt 2 (0x100), clock interrupt 3 (0x180), device interrupt 4 (0x200), memory-management fault 5 (0x280), unaligned access 6 (0x300), illegal opcode 7 (0x380), arithmetic trap 8 (0x400), FP disabled 9 (0x480).
- R2: Cause code 10 is the call cause. When call code bit 7 is 0, the offset is 0x1000 + code[6:0]×64.
- R3: For the call cause, when call code bit 7 is 1, the offset is 0x2000 + code[6:0]×64.
- R4: After a valid take, `exc_addr_o` equals `cur_pc_i | mode_i`, with the mode flag ORed into bit 0.
- R5: After a valid take, `pc_o` equals `base_i` + offset, taken modulo 2^64, one cycle after the take.
- R6: After a valid take, `priv_o` is 1.
- R7: A take with cause 11..15 sets `err_o`, and `err_o` then stays set until reset. Such a take leaves `pc_o`, `exc_addr_o` and `priv_o` unchanged.
- R8: In a cycle without a take, `pc_o`, `exc_addr_o` and `priv_o` hold their values.
- R9: Reset clears `pc_o`, `exc_addr_o`, `priv_o` and `err_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| take_i | input | 1 | One-cycle strobe that takes the exception |
| cause_i | input | 4 | Cause code |
| call_code_i | input | 8 | Call code, used only by the call cause |
| cur_pc_i | input | 64 | PC at the point of the exception |
| base_i | input | 64 | Privileged handler base register |
| mode_i | input | 1 | Current privileged-mode flag |
| pc_o | output | 64 | Registered handler PC |
| exc_addr_o | output | 64 | Registered saved exception address |
| priv_o | output | 1 | Registered privileged-mode flag |
| err_o | output | 1 | Sticky flag for an unknown cause |

## Verification
Assertions check four things on every cycle. The mode flag becomes 1 after each valid take. The low bit of the saved address follows the previous cycle's mode input. The error flag stays set once raised. The registers hold their values in cycles without a take and after unknown causes. Assertions cannot show that each particular cause lands on its correct offset, or that the two call regions and the base-plus-offset wraparound are right. The bench's directed and random scenarios cover those, checking them against its own offset model.

// File: rtl/exc_vec_pkg.sv
package exc_vec_pkg;
  localparam int CAUSE_W = 4;

  typedef enum logic [CAUSE_W-1:0] {
    CS_RESET   = 4'd0,
    CS_MCHECK  = 4'd1,
    CS_IPI     = 4'd2,
    CS_CLOCK   = 4'd3,
    CS_DEVICE  = 4'd4,
    CS_MMFAULT = 4'd5,
    CS_UNALIGN = 4'd6,
    CS_BADOP   = 4'd7,
    CS_ARITH   = 4'd8,
    CS_FPOFF   = 4'd9,
    CS_CALL    = 4'd10
  } cause_e;

  localparam int NUM_FIXED = 10;
endpackage

// File: rtl/exc_fixed_offset.sv
module exc_fixed_offset
  import exc_vec_pkg::*;
#(
  parameter int XLEN         = 64,
  parameter int FIXED_STRIDE = 128
) (
  input  logic [CAUSE_W-1:0] cause_i,
  output logic [XLEN-1:0]    off_o,
  output logic               hit_o
);
  logic [XLEN-1:0] table_w [NUM_FIXED];

  for (genvar g = 0; g < NUM_FIXED; g++) begin : g_tab
    assign table_w[g] = XLEN'(g * FIXED_STRIDE);
  end

  always_comb begin
    off_o = '0;
    hit_o = 1'b0;
    for (int k = 0; k < NUM_FIXED; k++) begin
      if (cause_i == CAUSE_W'(k)) begin
        off_o = table_w[k];
        hit_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/exc_call_slot.sv
module exc_call_slot #(
  parameter int XLEN       = 64,
  parameter int CODE_W     = 8,
  parameter int SLOT_BYTES = 64,
  parameter int PRIV_BASE  = 32'h1000,
  parameter int USER_BASE  = 32'h2000
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [XLEN-1:0]   off_o
);
  localparam int SLOT_SHIFT = $clog2(SLOT_BYTES);

  logic [CODE_W-2:0] slot_idx;
  logic [XLEN-1:0]   region;

  assign slot_idx = code_i[CODE_W-2:0];
  assign region   = code_i[CODE_W-1] ? XLEN'(USER_BASE) : XLEN'(PRIV_BASE);
  assign off_o    = region + (XLEN'(slot_idx) << SLOT_SHIFT);
endmodule

// File: rtl/exc_state_regs.sv
module exc_state_regs #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take_i,
  input  logic            known_i,
  input  logic [XLEN-1:0] target_i,
  input  logic [XLEN-1:0] cur_pc_i,
  input  logic            mode_i,
  output logic [XLEN-1:0] pc_o,
  output logic [XLEN-1:0] exc_addr_o,
  output logic            priv_o,
  output logic            err_o
);
  logic do_enter;
  logic do_bad;

  assign do_enter = take_i & known_i;
  assign do_bad   = take_i & ~known_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_o       <= '0;
      exc_addr_o <= '0;
      priv_o     <= 1'b0;
      err_o      <= 1'b0;
    end else begin
      if (do_enter) begin
        pc_o       <= target_i;
        exc_addr_o <= {cur_pc_i[XLEN-1:1], cur_pc_i[0] | mode_i};
        priv_o     <= 1'b1;
      end
      if (do_bad) err_o <= 1'b1;
    end
  end

  AST_PRIV_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && known_i) |=> priv_o); // R6
  AST_MODE_IN_LOW_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && known_i) |=> (exc_addr_o[0] == ($past(mode_i) | $past(cur_pc_i[0])))); // R4
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o); // R7
  AST_BAD_CAUSE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && !known_i) |=> ($stable(pc_o) && $stable(exc_addr_o) && $stable(priv_o) && err_o)); // R7
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !take_i |=> ($stable(pc_o) && $stable(exc_addr_o) && $stable(priv_o))); // R8
endmodule

// File: rtl/exc_vector_unit.sv
module exc_vector_unit
  import exc_vec_pkg::*;
#(
  parameter int XLEN         = 64,
  parameter int CODE_W       = 8,
  parameter int FIXED_STRIDE = 128,
  parameter int SLOT_BYTES   = 64,
  parameter int PRIV_BASE    = 32'h1000,
  parameter int USER_BASE    = 32'h2000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take_i,
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic [CODE_W-1:0]  call_code_i,
  input  logic [XLEN-1:0]    cur_pc_i,
  input  logic [XLEN-1:0]    base_i,
  input  logic               mode_i,
  output logic [XLEN-1:0]    pc_o,
  output logic [XLEN-1:0]    exc_addr_o,
  output logic               priv_o,
  output logic               err_o
);
  logic [XLEN-1:0] fixed_off;
  logic            fixed_hit;
  logic [XLEN-1:0] call_off;
  logic            is_call;
  logic            known;
  logic [XLEN-1:0] target;

  exc_fixed_offset #(.XLEN(XLEN), .FIXED_STRIDE(FIXED_STRIDE)) u_fixed (
    .cause_i (cause_i),
    .off_o   (fixed_off),
    .hit_o   (fixed_hit)
  );

  exc_call_slot #(
    .XLEN(XLEN), .CODE_W(CODE_W), .SLOT_BYTES(SLOT_BYTES),
    .PRIV_BASE(PRIV_BASE), .USER_BASE(USER_BASE)
  ) u_call (
    .code_i (call_code_i),
    .off_o  (call_off)
  );

  assign is_call = (cause_i == CS_CALL);
  assign known   = fixed_hit | is_call;
  assign target  = base_i + (is_call ? call_off : fixed_off);

  AST_CALL_SLOT_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    is_call |-> (call_off[$clog2(SLOT_BYTES)-1:0] == '0)); // R2

  exc_state_regs #(.XLEN(XLEN)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .take_i     (take_i),
    .known_i    (known),
    .target_i   (target),
    .cur_pc_i   (cur_pc_i),
    .mode_i     (mode_i),
    .pc_o       (pc_o),
    .exc_addr_o (exc_addr_o),
    .priv_o     (priv_o),
    .err_o      (err_o)
  );
endmodule

// File: tb/exc_vector_unit_bench.sv
module exc_vector_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        take_i = 1'b0;
  logic [3:0]  cause_i = '0;
  logic [7:0]  call_code_i = '0;
  logic [63:0] cur_pc_i = '0;
  logic [63:0] base_i = '0;
  logic        mode_i = 1'b0;
  logic [63:0] pc_o, exc_addr_o;
  logic        priv_o, err_o;

  int n_chk = 0;
  int n_bad = 0;

  logic [63:0] m_pc = '0, m_exc = '0;
  logic        m_priv = 1'b0, m_err = 1'b0;

  always #10 clk = ~clk;

  exc_vector_unit u_exc_vector_unit (
    .clk(clk), .rst_n(rst_n), .take_i(take_i), .cause_i(cause_i),
    .call_code_i(call_code_i), .cur_pc_i(cur_pc_i), .base_i(base_i),
    .mode_i(mode_i), .pc_o(pc_o), .exc_addr_o(exc_addr_o),
    .priv_o(priv_o), .err_o(err_o)
  );

  function automatic logic [63:0] exp_off(input logic [3:0] c, input logic [7:0] code);
    if (c <= 4'd9) return 64'(c) * 64'h80;
    if (code[7]) return 64'h2000 + 64'(code[6:0]) * 64;
    return 64'h1000 + 64'(code[6:0]) * 64;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic compare_all(input string req);
    check({req, " pc"}, pc_o, m_pc);
    check({req, " exc_addr"}, exc_addr_o, m_exc);
    check({req, " priv"}, 64'(priv_o), 64'(m_priv));
    check({req, " err"}, 64'(err_o), 64'(m_err));
  endtask

  task automatic step(input logic tk, input logic [3:0] c, input logic [7:0] code,
                      input logic [63:0] pc, input logic [63:0] base, input logic md,
                      input string req);
    take_i = tk; cause_i = c; call_code_i = code;
    cur_pc_i = pc; base_i = base; mode_i = md;
    @(posedge clk);
    if (tk) begin
      if (c <= 4'd10) begin
        m_pc = base + exp_off(c, code);
        m_exc = pc | 64'(md);
        m_priv = 1'b1;
      end else m_err = 1'b1;
    end
    @(negedge clk);
    take_i = 1'b0;
    compare_all(req);
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    compare_all("R9 reset");
    rst_n = 1'b1;
    @(negedge clk);
    // R1 each fixed cause
    for (int c = 0; c < 10; c++)
      step(1'b1, 4'(c), 8'hFF, 64'h4000_0000 + 64'(c) * 8, 64'h9000, 1'b0, "R1 fixed");
    // R2 privileged call slots, edges
    step(1'b1, 4'd10, 8'h00, 64'h100, 64'h0, 1'b0, "R2 call lo");
    step(1'b1, 4'd10, 8'h3F, 64'h104, 64'h10000, 1'b0, "R2 call slot63");
    // R3 unprivileged call slots
    step(1'b1, 4'd10, 8'h80, 64'h108, 64'h10000, 1'b0, "R3 user lo");
    step(1'b1, 4'd10, 8'hBF, 64'h10C, 64'h10000, 1'b1, "R3 user slot63");
    // R4 mode folded into bit 0
    step(1'b1, 4'd3, 8'h00, 64'hABCD_0000, 64'h0, 1'b1, "R4 mode bit");
    // R5 wraparound of base+offset
    step(1'b1, 4'd9, 8'h00, 64'h20, 64'hFFFF_FFFF_FFFF_FF80, 1'b0, "R5 wrap");
    // R8 idle holds
    step(1'b0, 4'd4, 8'h12, 64'h5555, 64'h7777, 1'b1, "R8 idle");
    // R7 unknown cause: holds, sets sticky err
    step(1'b1, 4'd13, 8'h01, 64'h6666, 64'h8888, 1'b0, "R7 unknown");
    step(1'b1, 4'd2, 8'h01, 64'h7000, 64'h1_0000, 1'b0, "R7 err sticky");
    // R6 priv forced after reset cleared it
    rst_n = 1'b0; m_pc = '0; m_exc = '0; m_priv = 1'b0; m_err = 1'b0;
    @(negedge clk);
    compare_all("R9 second reset");
    rst_n = 1'b1;
    @(negedge clk);
    step(1'b1, 4'd0, 8'h00, 64'h40, 64'h3_0000, 1'b0, "R6 priv set");
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [3:0] rc;
      rc = ($urandom % 8 == 0) ? 4'($urandom % 16) : 4'($urandom % 11);
      step(($urandom % 4) != 0, rc, 8'($urandom),
           {$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom),
           "R1 R2 R3 R4 R5 R7 R8 random");
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule